// File: doc/BRIEF.md
# CAN Mailbox Acceptance Filter and Transmit Arbiter

This block keeps sixteen CAN message mailboxes and works at the frame level, above the serial bit engine. When the bit engine finishes receiving a frame, it presents the identifier, the format flag, the length code and the payload for one cycle. The block compares the frame against every mailbox armed for reception, using acceptance masks, and stores it in the chosen mailbox. On the transmit side, it continuously offers the bit engine one pending mailbox, picked by a programmable ordering rule. The bit engine reports back when that frame has gone out.

Every stored or sent frame is stamped from a free-running 16-bit counter. A flat register port sets up the mailboxes, the masks, the ordering mode and the per-mailbox event flags. Mailboxes 0 to 13 share one mask. The last two mailboxes each have a private mask, so they can watch identifier ranges that the shared mask cannot express.

Top module: `can_mbox_hub`

## Requirements
- R1: After reset, every mailbox control word reads 0 (state off), the event flags read 0, `tx_req` and `irq` are low. Mailbox registers sit at address `idx*8+field`: field 0 is control (bits 1:0 state with 0 off, 1 armed for receive, 2 receive full, 3 transmit pending; bit 2 extended flag; bits 7:4 length code), field 1 is identifier, fields 2 and 3 are payload low and high words, field 4 is the stamp.
- R2: The stamp counter at address 0x93 advances by one every clock and wraps at 16 bits.
- R3: Mailboxes 0 to 13 compare against the shared mask at address 0x80. A mask bit of 1 requires that identifier bit to be equal, and a mask bit of 0 ignores it.
- R4: Mailbox 14 uses the private mask at address 0x81 and mailbox 15 the one at 0x82. The shared mask does not affect them.
- R5: Only mailboxes in the armed state whose extended flag equals the frame's flag can accept. For standard frames, only identifier and mask bits 10:0 take part.
- R6: When several mailboxes accept a frame, the lowest-indexed one takes it. A frame that no mailbox accepts changes no mailbox.
- R7: An accepted frame writes its identifier, flag, length and payload into the mailbox. It moves the mailbox to the full state and stores the stamp counter value from the cycle `rx_valid` was high. One cycle later, `rx_accept` pulses with the mailbox index.
- R8: With the order bit (address 0x90, bit 0) at 0, `tx_req` offers the lowest-indexed pending mailbox.
- R9: With the order bit at 1, the pending mailbox with the best bus priority is offered. The comparison is on the 11-bit base identifier first, then standard before extended, then the 18-bit extension. Equal keys go to the lower index.
- R10: `tx_done` while `tx_req` is high turns the offered mailbox off and stamps it with the counter value of that cycle.
- R11: Event flags at address 0x91 set on every accept and every completed send, and clear by writing 1 (a 0 leaves them). `irq` is the OR of the flags ANDed with the enables at address 0x92.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_ide | input | 1 | Received frame uses extended identifier |
| rx_id | input | 29 | Received identifier |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload |
| rx_accept | output | 1 | A frame was stored last cycle |
| rx_accept_idx | output | 4 | Mailbox that stored it |
| tx_req | output | 1 | A mailbox is pending for send |
| tx_idx | output | 4 | Offered mailbox |
| tx_ide | output | 1 | Offered frame format |
| tx_id | output | 29 | Offered identifier |
| tx_dlc | output | 4 | Offered length code |
| tx_data | output | 64 | Offered payload |
| tx_done | input | 1 | Offered frame has been sent |
| irq | output | 1 | Enabled event pending |

## Verification
The hardest cases to reach from the ports are the ordering corners: a standard frame and an extended frame with the same base identifier, and two pending mailboxes with identical keys. To reach them, the stimulus loads pending mailboxes one at a time and re-reads the offer after each write. Receive contention is handled the same way: several mailboxes are armed with one identifier, so successive identical frames fill them in index order until none is left. The private masks are tested with a frame that the shared mask rejects for a lower mailbox.

// File: rtl/can_mbox_pkg.sv
package can_mbox_pkg;
  localparam int ID_W   = 29;
  localparam int DATA_W = 64;
  localparam int TS_W   = 16;
  localparam int KEY_W  = 30;

  typedef enum logic [1:0] {
    MB_OFF      = 2'd0,
    MB_RX_ARMED = 2'd1,
    MB_RX_FULL  = 2'd2,
    MB_TX_PEND  = 2'd3
  } mb_state_e;

  typedef struct packed {
    mb_state_e          st;
    logic               ide;
    logic [3:0]         dlc;
    logic [ID_W-1:0]    id;
    logic [DATA_W-1:0]  data;
    logic [TS_W-1:0]    stamp;
  } mbox_t;

  // Bus priority key: base identifier, then format bit (standard wins), then extension
  function automatic logic [KEY_W-1:0] prio_key(input logic ide, input logic [ID_W-1:0] id);
    if (ide) return {id[28:18], 1'b1, id[17:0]};
    else     return {id[10:0], 1'b0, 18'd0};
  endfunction
endpackage

// File: rtl/can_stamp_timer.sv
module can_stamp_timer
  import can_mbox_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] count
);
  logic [TS_W-1:0] count_d;

  always_comb begin
    count_d = count + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == TS_W'($past(count) + TS_W'(1))); // R2
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_mbox_pkg::*;
#(
  parameter  int NUM_MB    = 16,
  parameter  int SHARED_MB = 14,
  localparam int IDX_W     = $clog2(NUM_MB),
  localparam int PRIV      = NUM_MB - SHARED_MB
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_MB-1:0]           armed,
  input  logic [NUM_MB-1:0]           mb_ide,
  input  logic [NUM_MB-1:0][ID_W-1:0] mb_id,
  input  logic [ID_W-1:0]             glob_mask,
  input  logic [PRIV-1:0][ID_W-1:0]   priv_mask,
  input  logic                        rx_ide,
  input  logic [ID_W-1:0]             rx_id,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [NUM_MB-1:0] match;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_cmp
    logic [ID_W-1:0] sel_mask;
    logic [ID_W-1:0] eff_mask;
    if (i < SHARED_MB) begin : g_shared
      assign sel_mask = glob_mask;
    end else begin : g_private
      assign sel_mask = priv_mask[i-SHARED_MB];
    end
    assign eff_mask = rx_ide ? sel_mask : {{(ID_W-11){1'b0}}, sel_mask[10:0]};
    assign match[i] = armed[i] && (mb_ide[i] == rx_ide) &&
                      (((rx_id ^ mb_id[i]) & eff_mask) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic [NUM_MB-1:0] below_hit;
  assign below_hit = (NUM_MB'(1) << hit_idx) - NUM_MB'(1);

  AST_RX_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[hit_idx] && ((match & below_hit) == '0))); // R6
  AST_RX_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> hit); // R6
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import can_mbox_pkg::*;
#(
  parameter  int NUM_MB = 16,
  localparam int IDX_W  = $clog2(NUM_MB)
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_MB-1:0]            pend,
  input  logic [NUM_MB-1:0][KEY_W-1:0] keys,
  input  logic                         by_id,
  output logic                         req,
  output logic [IDX_W-1:0]             idx
);
  logic [KEY_W-1:0] best;

  always_comb begin
    req  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pend[i] && (!req || (by_id && (keys[i] < best)))) begin
        req  = 1'b1;
        idx  = IDX_W'(i);
        best = keys[i];
      end
    end
  end

  logic [NUM_MB-1:0] below_sel;
  assign below_sel = (NUM_MB'(1) << idx) - NUM_MB'(1);

  AST_TX_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !by_id) |-> ((pend & below_sel) == '0)); // R8

  for (genvar i = 0; i < NUM_MB; i++) begin : g_key_chk
    AST_TX_KEY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (req && by_id && pend[i]) |->
        ((keys[i] > keys[idx]) || ((keys[i] == keys[idx]) && (IDX_W'(i) >= idx)))); // R9
  end
endmodule

// File: rtl/can_mbox_hub.sv
module can_mbox_hub
  import can_mbox_pkg::*;
#(
  parameter  int NUM_MB    = 16,
  parameter  int SHARED_MB = 14,
  localparam int IDX_W     = $clog2(NUM_MB),
  localparam int PRIV      = NUM_MB - SHARED_MB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic              rx_ide,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [3:0]        rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_accept,
  output logic [IDX_W-1:0]  rx_accept_idx,
  output logic              tx_req,
  output logic [IDX_W-1:0]  tx_idx,
  output logic              tx_ide,
  output logic [ID_W-1:0]   tx_id,
  output logic [3:0]        tx_dlc,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  output logic              irq
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // State
  mbox_t                     mb_q [NUM_MB];
  mbox_t                     mb_d [NUM_MB];
  logic [ID_W-1:0]           gmask_q, gmask_d;
  logic [PRIV-1:0][ID_W-1:0] pmask_q, pmask_d;
  logic                      by_id_q, by_id_d;
  logic [NUM_MB-1:0]         flags_q, flags_d;
  logic [NUM_MB-1:0]         ien_q, ien_d;
  logic                      acc_q, acc_d;
  logic [IDX_W-1:0]          acc_idx_q, acc_idx_d;
  logic [TS_W-1:0]           timer;

  can_stamp_timer u_timer (
    .clk   (clk),
    .rst_n (rst_q),
    .count (timer)
  );

  // Views of the mailbox bank for the selectors
  logic [NUM_MB-1:0]            armed_v, pend_v, ide_v;
  logic [NUM_MB-1:0][ID_W-1:0]  id_v;
  logic [NUM_MB-1:0][KEY_W-1:0] key_v;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_view
    assign armed_v[i] = (mb_q[i].st == MB_RX_ARMED);
    assign pend_v[i]  = (mb_q[i].st == MB_TX_PEND);
    assign ide_v[i]   = mb_q[i].ide;
    assign id_v[i]    = mb_q[i].id;
    assign key_v[i]   = prio_key(mb_q[i].ide, mb_q[i].id);
  end

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  can_acc_filter #(.NUM_MB(NUM_MB), .SHARED_MB(SHARED_MB)) u_filter (
    .clk       (clk),
    .rst_n     (rst_q),
    .armed     (armed_v),
    .mb_ide    (ide_v),
    .mb_id     (id_v),
    .glob_mask (gmask_q),
    .priv_mask (pmask_q),
    .rx_ide    (rx_ide),
    .rx_id     (rx_id),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  can_tx_arbiter #(.NUM_MB(NUM_MB)) u_arb (
    .clk   (clk),
    .rst_n (rst_q),
    .pend  (pend_v),
    .keys  (key_v),
    .by_id (by_id_q),
    .req   (tx_req),
    .idx   (tx_idx)
  );

  assign tx_ide  = mb_q[tx_idx].ide;
  assign tx_id   = mb_q[tx_idx].id;
  assign tx_dlc  = mb_q[tx_idx].dlc;
  assign tx_data = mb_q[tx_idx].data;

  // Register decode fields
  logic [IDX_W-1:0] reg_mb;
  logic [2:0]       reg_fld;
  logic             reg_glob;
  logic             rx_take, tx_take;

  assign reg_mb   = reg_addr[3 +: IDX_W];
  assign reg_fld  = reg_addr[2:0];
  assign reg_glob = reg_addr[7];
  assign rx_take  = rx_valid && hit;
  assign tx_take  = tx_done && tx_req;

  // Next state: software writes first, frame events override
  always_comb begin
    for (int i = 0; i < NUM_MB; i++) mb_d[i] = mb_q[i];
    gmask_d   = gmask_q;
    pmask_d   = pmask_q;
    by_id_d   = by_id_q;
    flags_d   = flags_q;
    ien_d     = ien_q;
    acc_d     = 1'b0;
    acc_idx_d = acc_idx_q;

    if (reg_we) begin
      if (!reg_glob) begin
        case (reg_fld)
          3'd0: begin
            mb_d[reg_mb].st  = mb_state_e'(reg_wdata[1:0]);
            mb_d[reg_mb].ide = reg_wdata[2];
            mb_d[reg_mb].dlc = reg_wdata[7:4];
          end
          3'd1: mb_d[reg_mb].id = reg_wdata[ID_W-1:0];
          3'd2: mb_d[reg_mb].data[31:0]  = reg_wdata;
          3'd3: mb_d[reg_mb].data[63:32] = reg_wdata;
          default: ;
        endcase
      end else begin
        case (reg_addr[6:0])
          7'h00: gmask_d = reg_wdata[ID_W-1:0];
          7'h10: by_id_d = reg_wdata[0];
          7'h11: flags_d = flags_q & ~reg_wdata[NUM_MB-1:0];
          7'h12: ien_d   = reg_wdata[NUM_MB-1:0];
          default: ;
        endcase
        for (int k = 0; k < PRIV; k++) begin
          if (reg_addr[6:0] == 7'(k + 1)) pmask_d[k] = reg_wdata[ID_W-1:0];
        end
      end
    end

    if (rx_take) begin
      mb_d[hit_idx].st    = MB_RX_FULL;
      mb_d[hit_idx].id    = rx_id;
      mb_d[hit_idx].ide   = rx_ide;
      mb_d[hit_idx].dlc   = rx_dlc;
      mb_d[hit_idx].data  = rx_data;
      mb_d[hit_idx].stamp = timer;
      flags_d[hit_idx]    = 1'b1;
      acc_d               = 1'b1;
      acc_idx_d           = hit_idx;
    end

    if (tx_take) begin
      mb_d[tx_idx].st    = MB_OFF;
      mb_d[tx_idx].stamp = timer;
      flags_d[tx_idx]    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < NUM_MB; i++) mb_q[i] <= '0;
      gmask_q   <= '0;
      pmask_q   <= '0;
      by_id_q   <= 1'b0;
      flags_q   <= '0;
      ien_q     <= '0;
      acc_q     <= 1'b0;
      acc_idx_q <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) mb_q[i] <= mb_d[i];
      gmask_q   <= gmask_d;
      pmask_q   <= pmask_d;
      by_id_q   <= by_id_d;
      flags_q   <= flags_d;
      ien_q     <= ien_d;
      acc_q     <= acc_d;
      if (rx_take) acc_idx_q <= acc_idx_d;
    end
  end

  assign rx_accept     = acc_q;
  assign rx_accept_idx = acc_idx_q;
  assign irq           = |(flags_q & ien_q);

  // Register read
  always_comb begin
    reg_rdata = '0;
    if (!reg_glob) begin
      case (reg_fld)
        3'd0: reg_rdata = {24'd0, mb_q[reg_mb].dlc, 1'b0, mb_q[reg_mb].ide, mb_q[reg_mb].st};
        3'd1: reg_rdata = 32'(mb_q[reg_mb].id);
        3'd2: reg_rdata = mb_q[reg_mb].data[31:0];
        3'd3: reg_rdata = mb_q[reg_mb].data[63:32];
        3'd4: reg_rdata = 32'(mb_q[reg_mb].stamp);
        default: reg_rdata = '0;
      endcase
    end else begin
      case (reg_addr[6:0])
        7'h00: reg_rdata = 32'(gmask_q);
        7'h10: reg_rdata = {31'd0, by_id_q};
        7'h11: reg_rdata = 32'(flags_q);
        7'h12: reg_rdata = 32'(ien_q);
        7'h13: reg_rdata = 32'(timer);
        default: reg_rdata = '0;
      endcase
      for (int k = 0; k < PRIV; k++) begin
        if (reg_addr[6:0] == 7'(k + 1)) reg_rdata = 32'(pmask_q[k]);
      end
    end
  end

  AST_RX_LANDS_FULL: assert property (@(posedge clk) disable iff (!rst_q)
    rx_accept |-> (mb_q[rx_accept_idx].st == MB_RX_FULL)); // R7
  AST_RX_STAMP: assert property (@(posedge clk) disable iff (!rst_q)
    rx_accept |-> (mb_q[rx_accept_idx].stamp == TS_W'(timer - TS_W'(1)))); // R7
  AST_TX_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_q)
    tx_req |-> (mb_q[tx_idx].st == MB_TX_PEND)); // R8
  AST_TX_RETIRE: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_done && tx_req) |=> (mb_q[$past(tx_idx)].st == MB_OFF)); // R10
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_done && tx_req) |=> flags_q[$past(tx_idx)]); // R11
endmodule

// File: tb/sim_can_mbox_hub.sv
module sim_can_mbox_hub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_ide;
  logic [28:0] rx_id;
  logic [3:0]  rx_dlc;
  logic [63:0] rx_data;
  logic        rx_accept;
  logic [3:0]  rx_accept_idx;
  logic        tx_req, tx_ide, tx_done, irq;
  logic [3:0]  tx_idx, tx_dlc;
  logic [28:0] tx_id;
  logic [63:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  logic [31:0] stamp_seen;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mbox_hub u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ide(rx_ide), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rx_accept(rx_accept), .rx_accept_idx(rx_accept_idx), .tx_req(tx_req),
    .tx_idx(tx_idx), .tx_ide(tx_ide), .tx_id(tx_id), .tx_dlc(tx_dlc),
    .tx_data(tx_data), .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mba(input int idx, input int fld);
    return 8'(idx * 8 + fld);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // Driver: pushes the expected accepting mailbox (or nothing) into the scoreboard
  task automatic send_rx(input logic [28:0] id, input logic ide, input logic [3:0] dlc,
                         input logic [63:0] data, input int exp_idx);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = data; rx_valid = 1'b1;
    rd(8'h93, stamp_seen);
    if (exp_idx >= 0) exp_q.push_back(exp_idx);
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_done();
    @(negedge clk);
    tx_done = 1'b1;
    rd(8'h93, stamp_seen);
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  // Monitor: pops and compares every accept the design reports
  always @(negedge clk) begin
    if (rst_n && rx_accept) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected accept actual=%0d expected=none", rx_accept_idx);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(rx_accept_idx) != e) begin
          n_fail++;
          $display("FAIL R7 accept index actual=%0d expected=%0d", rx_accept_idx, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] t1, t2;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_ide = 1'b0; rx_id = '0; rx_dlc = '0; rx_data = '0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(mba(0, 0), rv); chk("R1 ctrl mb0", rv, 0);
    rd(mba(15, 0), rv); chk("R1 ctrl mb15", rv, 0);
    rd(8'h91, rv); chk("R1 flags", rv, 0);

    // R2 stamp counter
    rd(8'h93, t1);
    repeat (5) @(negedge clk);
    rd(8'h93, t2);
    chk("R2 timer step", t2, 32'(16'(t1 + 5)));

    // R3 shared mask: low four bits ignored
    wr(8'h80, 32'h1FFF_FFF0);
    wr(mba(2, 1), 32'h1234_5670);
    wr(mba(2, 0), 32'h0000_0005);
    send_rx(29'h1234_567A, 1'b1, 4'd8, 64'h1122_3344_5566_7788, 2);
    rd(mba(2, 0), rv); chk("R7 ctrl full", rv, 32'h0000_0086);
    rd(mba(2, 1), rv); chk("R7 stored id", rv, 32'h1234_567A);
    rd(mba(2, 2), rv); chk("R7 data low", rv, 32'h5566_7788);
    rd(mba(2, 3), rv); chk("R7 data high", rv, 32'h1122_3344);
    rd(mba(2, 4), rv); chk("R7 rx stamp", rv, 32'(stamp_seen[15:0]));
    wr(mba(1, 1), 32'h1234_5670);
    wr(mba(1, 0), 32'h0000_0005);
    send_rx(29'h1234_5660, 1'b1, 4'd1, 64'h0, -1);
    rd(mba(1, 0), rv); chk("R3 masked bit mismatch keeps armed", rv, 32'h0000_0005);

    // R5 format and standard compare
    wr(mba(0, 1), 32'h0000_0123);
    wr(mba(0, 0), 32'h0000_0001);
    send_rx(29'h0000_0123, 1'b0, 4'd2, 64'hAB, 0);
    wr(mba(4, 1), 32'h0000_00AB);
    wr(mba(4, 0), 32'h0000_0001);
    send_rx(29'h0000_00AB, 1'b1, 4'd2, 64'h0, -1);
    rd(mba(4, 0), rv); chk("R5 format mismatch ignored", rv, 32'h0000_0001);

    // R6 contention: lowest index first
    wr(mba(5, 1), 32'h0000_02AA); wr(mba(5, 0), 32'h1);
    wr(mba(6, 1), 32'h0000_02AA); wr(mba(6, 0), 32'h1);
    send_rx(29'h0000_02AA, 1'b0, 4'd1, 64'h1, 5);
    send_rx(29'h0000_02AA, 1'b0, 4'd1, 64'h2, 6);
    send_rx(29'h0000_02AA, 1'b0, 4'd1, 64'h3, -1);
    rd(mba(6, 2), rv); chk("R6 second frame kept", rv, 32'h2);

    // R4 private masks
    wr(8'h80, 32'h1FFF_FFFF);
    wr(8'h81, 32'h0000_07F0);
    wr(8'h82, 32'h0000_07FF);
    wr(mba(7, 1), 32'h350);  wr(mba(7, 0), 32'h1);
    wr(mba(14, 1), 32'h350); wr(mba(14, 0), 32'h1);
    wr(mba(15, 1), 32'h351); wr(mba(15, 0), 32'h1);
    send_rx(29'h0000_035F, 1'b0, 4'd3, 64'h0, 14);
    send_rx(29'h0000_0351, 1'b0, 4'd3, 64'h0, 15);
    rd(mba(7, 0), rv); chk("R4 shared mask still exact", rv, 32'h1);

    for (int i = 0; i < 16; i++) wr(mba(i, 0), 32'h0);

    // R8 lowest index order
    wr(mba(9, 1), 32'h0000_0010);  wr(mba(9, 0), 32'h0000_0027);
    wr(mba(3, 1), 32'h0000_0700);  wr(mba(3, 0), 32'h0000_0013);
    wr(mba(12, 1), 32'h0000_0001); wr(mba(12, 0), 32'h0000_0003);
    chk("R8 req", 32'(tx_req), 1);
    chk("R8 idx", 32'(tx_idx), 3);
    chk("R8 id", 32'(tx_id), 32'h700);
    chk("R8 dlc", 32'(tx_dlc), 1);

    // R10 completion
    send_done();
    rd(mba(3, 0), rv); chk("R10 retired", rv, 32'h0000_0010);
    rd(mba(3, 4), rv); chk("R10 tx stamp", rv, 32'(stamp_seen[15:0]));
    chk("R8 next idx", 32'(tx_idx), 9);

    // R9 priority order
    wr(8'h90, 32'h1);
    chk("R9 ext base0 beats std 1", 32'(tx_idx), 9);
    wr(mba(10, 1), 32'h0); wr(mba(10, 0), 32'h3);
    chk("R9 std beats ext same base", 32'(tx_idx), 10);
    wr(mba(11, 1), 32'h0); wr(mba(11, 0), 32'h3);
    chk("R9 tie lower index", 32'(tx_idx), 10);
    wr(8'h90, 32'h0);
    chk("R8 back to index order", 32'(tx_idx), 9);

    // R11 flags and interrupt
    rd(8'h91, rv); chk("R11 flags", rv, 32'h0000_C06D);
    chk("R11 irq masked", 32'(irq), 0);
    wr(8'h92, 32'h0000_0008);
    chk("R11 irq enabled", 32'(irq), 1);
    wr(8'h91, 32'h0000_0000);
    rd(8'h91, rv); chk("R11 zero write keeps", rv, 32'h0000_C06D);
    wr(8'h91, 32'h0000_0008);
    rd(8'h91, rv); chk("R11 w1c", rv, 32'h0000_C065);
    chk("R11 irq cleared", 32'(irq), 0);

    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 missing accepts actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule